// File: doc/BRIEF.md
# Two-Wire Slave Status Flag Controller

This block keeps the status flags of a byte-oriented two-wire serial slave. A separate bus engine does the bit shifting and the address comparison and reports its results as single-cycle strobes: start seen, stop seen, byte finished (with its direction), address matched, acknowledge missing and bus error. The block turns these strobes into a packed 8-bit status value, a group of error flags, an interrupt pulse and a clock-stretch request that holds the clock line low while software still has to deal with a transfer.

Software clears the flags through register accesses, reported to the block as one-cycle strobes. The address flag clears on a read of the first status register. The byte-finished flag needs two steps: a status read while it is set, and then a data access whose type matches the direction of the byte. The error flags clear on a read of the second status register. When the interface enable is low, every flag except bus busy is held clear.

Top module: `tws_status_ctrl`

## Requirements
- R1: After reset, `status_o` is 8'h00, `err_o` is 3'b000, and `irq_o` and `stretch_o` are 0.
- R2: `status_o` packs the flags as bit 7 event (1 when enabled and any of byte-finished, address-matched or an error flag is set), bit 5 direction (1 = transmitted), bit 4 busy, bit 3 byte-finished and bit 2 address-matched. Bits 6, 1 and 0 always read 0.
- R3: Busy goes to 1 the cycle after `ev_start` and to 0 the cycle after `ev_stop`, whatever the value of `en`. When both strobes arrive in the same cycle, start wins.
- R4: `ev_byte_done` sets byte-finished in the next cycle when `ev_byte_tx`=1, or when `ev_byte_tx`=0 and `ack_en`=1. A received byte with `ack_en`=0 leaves the flag unchanged. The direction bit takes the value of `ev_byte_tx` when the flag is set.
- R5: After a transmitted byte, a `rd_sr1` while byte-finished is 1 arms the clear. The next `wr_dr` then clears byte-finished and direction. If a `rd_dr` comes first instead, it uses up the armed state and clears nothing. A `rd_sr2` in between does not disarm.
- R6: After a received byte, a `rd_sr1` while byte-finished is 1 followed by `rd_dr` clears byte-finished. A `wr_dr` as the data access uses up the armed state and clears nothing.
- R7: `ev_addr_match` sets address-matched in the next cycle. A `rd_sr1` clears it.
- R8: `err_o` bit 0 (missing acknowledge), bit 1 (stop) and bit 2 (bus error) are set by their strobes and cleared by `rd_sr2`. A stop also clears the direction bit unless a byte is set in the same cycle.
- R9: `stretch_o` is 1 exactly when byte-finished or address-matched is 1.
- R10: `irq_o` pulses for one cycle, in the cycle where byte-finished or address-matched rises from 0 to 1, and only when `irq_en`=1.
- R11: While `en`=0, all flags except busy are cleared in the next cycle, and all event strobes except start and stop-for-busy are ignored.
- R12: A hardware set in the same cycle as a software clear wins, so the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enable |
| irq_en | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge enable for received bytes |
| ev_start | input | 1 | Start condition strobe |
| ev_stop | input | 1 | Stop condition strobe |
| ev_byte_done | input | 1 | Byte finished strobe |
| ev_byte_tx | input | 1 | Direction of finished byte, 1 = transmitted |
| ev_addr_match | input | 1 | Own address matched strobe |
| ev_ack_fail | input | 1 | No acknowledge received strobe |
| ev_bus_err | input | 1 | Misplaced start/stop strobe |
| rd_sr1 | input | 1 | Status register 1 read strobe |
| rd_sr2 | input | 1 | Status register 2 read strobe |
| rd_dr | input | 1 | Data register read strobe |
| wr_dr | input | 1 | Data register write strobe |
| status_o | output | 8 | Packed status register 1 value |
| err_o | output | 3 | Error flags {bus error, stop, missing acknowledge} |
| irq_o | output | 1 | Interrupt pulse |
| stretch_o | output | 1 | Clock-stretch request |

## Verification
The flags are all visible at the ports, so a wrong internal state shows one cycle after the strobe that caused it. The armed bit is the exception. A lost or stale armed bit shows only at the next data access, as byte-finished and `stretch_o` staying set or clearing too early. The bench therefore runs access sequences with a status-2 read and a wrong-type data access placed between the steps. A missed or repeated interrupt shows as `irq_o` disagreeing with the rising edge of bit 3 or bit 2 in the same cycle.

// File: rtl/tws_pkg.sv
package tws_pkg;
    localparam int SR_W   = 8;
    localparam int N_ERR  = 3;
    localparam int B_EVF  = 7;
    localparam int B_TRA  = 5;
    localparam int B_BUSY = 4;
    localparam int B_BTF  = 3;
    localparam int B_ADSL = 2;
    localparam int E_ACK  = 0;
    localparam int E_STOP = 1;
    localparam int E_BERR = 2;

    typedef struct packed {
        logic             busy;
        logic             btf;
        logic             tra;
        logic             adsl;
        logic [N_ERR-1:0] err;
    } flags_t;

    function automatic logic [SR_W-1:0] pack_status(flags_t f, logic en);
        logic [SR_W-1:0] s;
        s         = '0;
        s[B_EVF]  = en & (f.btf | f.adsl | (|f.err));
        s[B_TRA]  = f.tra;
        s[B_BUSY] = f.busy;
        s[B_BTF]  = f.btf;
        s[B_ADSL] = f.adsl;
        return s;
    endfunction
endpackage

// File: rtl/tws_busy_trk.sv
module tws_busy_trk (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic stop_i,
    output logic busy_o
);
    always_ff @(posedge clk) begin
        if (rst)          busy_o <= 1'b0;
        else if (start_i) busy_o <= 1'b1;
        else if (stop_i)  busy_o <= 1'b0;
    end
endmodule

// File: rtl/tws_err_flags.sv
module tws_err_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] err_o
);
    for (genvar i = 0; i < N; i++) begin : g_err
        always_ff @(posedge clk) begin
            if (rst || !en)    err_o[i] <= 1'b0;
            else if (set_i[i]) err_o[i] <= 1'b1;
            else if (clr_i)    err_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/tws_xfer_flags.sv
module tws_xfer_flags (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic irq_en,
    input  logic ack_en,
    input  logic byte_done_i,
    input  logic byte_tx_i,
    input  logic addr_match_i,
    input  logic stop_i,
    input  logic rd_sr1_i,
    input  logic rd_dr_i,
    input  logic wr_dr_i,
    output logic btf_o,
    output logic tra_o,
    output logic adsl_o,
    output logic irq_o
);
    logic armed_q;
    logic btf_set, btf_clr, btf_d, tra_d, adsl_d, armed_d, dr_acc;

    always_comb begin
        dr_acc  = rd_dr_i | wr_dr_i;
        btf_set = byte_done_i & (byte_tx_i | ack_en);
        btf_clr = armed_q & ((tra_o & wr_dr_i) | (!tra_o & rd_dr_i));
        btf_d   = btf_set | (btf_o & !btf_clr);
        if (btf_set)             tra_d = byte_tx_i;
        else if (stop_i || !btf_d) tra_d = 1'b0;
        else                     tra_d = tra_o;
        if (dr_acc)                   armed_d = 1'b0;
        else if (rd_sr1_i && btf_o)   armed_d = 1'b1;
        else                          armed_d = armed_q;
        adsl_d = addr_match_i | (adsl_o & !rd_sr1_i);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            btf_o   <= 1'b0;
            tra_o   <= 1'b0;
            adsl_o  <= 1'b0;
            armed_q <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            btf_o   <= btf_d;
            tra_o   <= tra_d;
            adsl_o  <= adsl_d;
            armed_q <= armed_d;
            irq_o   <= irq_en & ((btf_d & !btf_o) | (adsl_d & !adsl_o));
        end
    end
endmodule

// File: rtl/tws_status_ctrl.sv
module tws_status_ctrl
    import tws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             irq_en,
    input  logic             ack_en,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             ev_byte_done,
    input  logic             ev_byte_tx,
    input  logic             ev_addr_match,
    input  logic             ev_ack_fail,
    input  logic             ev_bus_err,
    input  logic             rd_sr1,
    input  logic             rd_sr2,
    input  logic             rd_dr,
    input  logic             wr_dr,
    output logic [SR_W-1:0]  status_o,
    output logic [N_ERR-1:0] err_o,
    output logic             irq_o,
    output logic             stretch_o
);
    flags_t           fl;
    logic [N_ERR-1:0] err_set;

    always_comb begin
        err_set         = '0;
        err_set[E_ACK]  = ev_ack_fail;
        err_set[E_STOP] = ev_stop;
        err_set[E_BERR] = ev_bus_err;
    end

    tws_busy_trk u_busy (
        .clk(clk), .rst(rst), .start_i(ev_start), .stop_i(ev_stop), .busy_o(fl.busy)
    );

    tws_xfer_flags u_xfer (
        .clk(clk), .rst(rst), .en(en), .irq_en(irq_en), .ack_en(ack_en),
        .byte_done_i(ev_byte_done), .byte_tx_i(ev_byte_tx),
        .addr_match_i(ev_addr_match), .stop_i(ev_stop),
        .rd_sr1_i(rd_sr1), .rd_dr_i(rd_dr), .wr_dr_i(wr_dr),
        .btf_o(fl.btf), .tra_o(fl.tra), .adsl_o(fl.adsl), .irq_o(irq_o)
    );

    tws_err_flags #(.N(N_ERR)) u_err (
        .clk(clk), .rst(rst), .en(en), .set_i(err_set), .clr_i(rd_sr2), .err_o(fl.err)
    );

    always_comb begin
        status_o  = pack_status(fl, en);
        err_o     = fl.err;
        stretch_o = fl.btf | fl.adsl;
    end
endmodule

// File: rtl/tws_status_chk.sv
module tws_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       ack_en,
    input logic       ev_start,
    input logic       ev_byte_done,
    input logic       ev_byte_tx,
    input logic       ev_addr_match,
    input logic       ev_ack_fail,
    input logic       ev_stop,
    input logic       ev_bus_err,
    input logic       rd_sr2,
    input logic       rd_dr,
    input logic       wr_dr,
    input logic [7:0] status_o,
    input logic [2:0] err_o,
    input logic       irq_o,
    input logic       stretch_o
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o[6] == 1'b0) && (status_o[1:0] == 2'b00));
    // R3
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> status_o[4]);
    // R4
    rx_noack_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ev_byte_done && !ev_byte_tx && !ack_en && !status_o[3]) |=> !status_o[3]);
    // R5
    btf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && status_o[3] && !rd_dr && !wr_dr) |=> status_o[3]);
    // R7
    adsl_set_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ev_addr_match) |=> status_o[2]);
    // R8
    err_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_sr2 && !ev_ack_fail && !ev_stop && !ev_bus_err) |=> (err_o == 3'b000));
    // R9
    stretch_chk: assert property (@(posedge clk) disable iff (rst)
        stretch_o == (status_o[3] | status_o[2]));
    // R10
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> stretch_o);
    // R11
    disable_clr_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ((status_o & 8'hEF) == 8'h00) && (err_o == 3'b000) && !irq_o);
endmodule

bind tws_status_ctrl tws_status_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .ack_en(ack_en), .ev_start(ev_start),
    .ev_byte_done(ev_byte_done), .ev_byte_tx(ev_byte_tx),
    .ev_addr_match(ev_addr_match), .ev_ack_fail(ev_ack_fail),
    .ev_stop(ev_stop), .ev_bus_err(ev_bus_err), .rd_sr2(rd_sr2),
    .rd_dr(rd_dr), .wr_dr(wr_dr), .status_o(status_o), .err_o(err_o),
    .irq_o(irq_o), .stretch_o(stretch_o)
);

// File: tb/tws_status_ctrl_tb.sv
`timescale 1ns/1ps
module tws_status_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, irq_en = 0, ack_en = 0;
    logic ev_start = 0, ev_stop = 0, ev_byte_done = 0, ev_byte_tx = 0;
    logic ev_addr_match = 0, ev_ack_fail = 0, ev_bus_err = 0;
    logic rd_sr1 = 0, rd_sr2 = 0, rd_dr = 0, wr_dr = 0;
    logic [7:0] status_o;
    logic [2:0] err_o;
    logic irq_o, stretch_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of the flags
    logic m_busy = 0, m_btf = 0, m_tra = 0, m_adsl = 0, m_arm = 0, m_irq = 0;
    logic [2:0] m_err = 0;

    always #4 clk = ~clk;

    tws_status_ctrl u_dut (
        .clk(clk), .rst(rst), .en(en), .irq_en(irq_en), .ack_en(ack_en),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte_done(ev_byte_done),
        .ev_byte_tx(ev_byte_tx), .ev_addr_match(ev_addr_match),
        .ev_ack_fail(ev_ack_fail), .ev_bus_err(ev_bus_err),
        .rd_sr1(rd_sr1), .rd_sr2(rd_sr2), .rd_dr(rd_dr), .wr_dr(wr_dr),
        .status_o(status_o), .err_o(err_o), .irq_o(irq_o), .stretch_o(stretch_o)
    );

    function automatic logic [7:0] exp_status();
        logic ev;
        ev = en & (m_btf | m_adsl | (|m_err));
        return {ev, 1'b0, m_tra, m_busy, m_btf, m_adsl, 2'b00};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic sb, cb, nb, nt, na, ni;
        logic [2:0] ne;
        if (ev_start) m_busy = 1;
        else if (ev_stop) m_busy = 0;
        if (!en) begin
            m_btf = 0; m_tra = 0; m_adsl = 0; m_arm = 0; m_err = 0; m_irq = 0;
        end else begin
            sb = ev_byte_done & (ev_byte_tx | ack_en);                 // R4
            cb = m_arm & ((m_tra & wr_dr) | (!m_tra & rd_dr));        // R5 R6
            nb = sb | (m_btf & !cb);                                  // R12
            nt = sb ? ev_byte_tx : ((ev_stop || !nb) ? 1'b0 : m_tra);
            na = ev_addr_match | (m_adsl & !rd_sr1);                  // R7
            ne = {ev_bus_err, ev_stop, ev_ack_fail} | (m_err & {3{!rd_sr2}}); // R8
            ni = irq_en & ((nb & !m_btf) | (na & !m_adsl));           // R10
            if (rd_dr || wr_dr) m_arm = 0;
            else if (rd_sr1 && m_btf) m_arm = 1;
            m_btf = nb; m_tra = nt; m_adsl = na; m_err = ne; m_irq = ni;
        end
    endtask

    task automatic clear_strobes();
        ev_start = 0; ev_stop = 0; ev_byte_done = 0; ev_byte_tx = 0;
        ev_addr_match = 0; ev_ack_fail = 0; ev_bus_err = 0;
        rd_sr1 = 0; rd_sr2 = 0; rd_dr = 0; wr_dr = 0;
    endtask

    // one clock: inputs already driven; update model at edge, compare after
    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        #1;
        chk({tag, " R2 status"}, status_o, exp_status());
        chk({tag, " R8 err"}, {5'b0, err_o}, {5'b0, m_err});
        chk({tag, " R9 stretch"}, {7'b0, stretch_o}, {7'b0, m_btf | m_adsl});
        chk({tag, " R10 irq"}, {7'b0, irq_o}, {7'b0, m_irq});
        clear_strobes();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 status", status_o, 8'h00);
        chk("R1 err", {5'b0, err_o}, 8'h00);
        chk("R1 irq/stretch", {6'b0, irq_o, stretch_o}, 8'h00);
        en = 1; irq_en = 1; ack_en = 1;

        ev_start = 1; tick("R3 start");
        chk("R3 busy", status_o, 8'h10);
        ev_addr_match = 1; tick("R7 match");
        chk("R7 adsl", status_o, 8'h94);
        chk("R10 irq on adsl", {7'b0, irq_o}, 8'h01);
        tick("R10 pulse end");
        chk("R10 one cycle", {7'b0, irq_o}, 8'h00);
        rd_sr1 = 1; ev_addr_match = 1; tick("R12 adsl set wins");
        chk("R12 adsl", status_o, 8'h94);
        rd_sr1 = 1; tick("R7 clear");
        chk("R7 cleared", status_o, 8'h10);

        ev_byte_done = 1; ev_byte_tx = 1; tick("R4 tx");
        chk("R4 tx byte", status_o, 8'hB8);
        rd_sr1 = 1; tick("R5 arm");
        rd_sr2 = 1; tick("R5 sr2 keeps arm");
        rd_dr = 1; tick("R5 wrong access");
        chk("R5 rd_dr no clear", status_o, 8'hB8);
        wr_dr = 1; tick("R5 disarmed");
        chk("R5 arm used up", status_o, 8'hB8);
        rd_sr1 = 1; tick("R5 rearm");
        rd_sr2 = 1; tick("R5 sr2");
        wr_dr = 1; tick("R5 clear");
        chk("R5 tx cleared", status_o, 8'h10);

        ack_en = 0; ev_byte_done = 1; ev_byte_tx = 0; tick("R4 rx no ack");
        chk("R4 rx ignored", status_o, 8'h10);
        ack_en = 1; ev_byte_done = 1; ev_byte_tx = 0; tick("R4 rx");
        chk("R4 rx byte", status_o, 8'h98);
        rd_sr1 = 1; tick("R6 arm");
        wr_dr = 1; tick("R6 wrong access");
        chk("R6 wr_dr no clear", status_o, 8'h98);
        rd_sr1 = 1; tick("R6 rearm");
        rd_dr = 1; ev_byte_done = 1; ev_byte_tx = 1; tick("R12 btf set wins");
        chk("R12 btf", status_o, 8'hB8);
        rd_sr1 = 1; tick("R5 arm2");
        wr_dr = 1; tick("R5 clear2");

        ev_stop = 1; ev_ack_fail = 1; tick("R8 stop");
        chk("R8 stop flags", status_o, 8'h80);
        chk("R8 err bits", {5'b0, err_o}, 8'h03);
        ev_bus_err = 1; rd_sr2 = 1; tick("R12 err set wins");
        chk("R12 berr", {5'b0, err_o}, 8'h04);
        rd_sr2 = 1; tick("R8 clear");
        chk("R8 cleared", status_o, 8'h00);

        ev_addr_match = 1; tick("R11 pre");
        en = 0; ev_byte_done = 1; ev_byte_tx = 1; ev_start = 1; tick("R11 off");
        chk("R11 disabled", status_o, 8'h10);
        ev_stop = 1; tick("R3 stop while off");
        chk("R3 busy off", status_o, 8'h00);
        en = 1;

        for (int i = 0; i < 4000; i++) begin
            en = ($urandom % 40) != 0;
            irq_en = $urandom % 2;
            ack_en = ($urandom % 4) != 0;
            ev_start = ($urandom % 12) == 0;
            ev_stop = ($urandom % 14) == 0;
            ev_byte_done = ($urandom % 6) == 0;
            ev_byte_tx = $urandom % 2;
            ev_addr_match = ($urandom % 10) == 0;
            ev_ack_fail = ($urandom % 20) == 0;
            ev_bus_err = ($urandom % 25) == 0;
            rd_sr1 = ($urandom % 4) == 0;
            rd_sr2 = ($urandom % 5) == 0;
            rd_dr = ($urandom % 5) == 0;
            wr_dr = ($urandom % 5) == 0;
            tick("rand");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule